// File: doc/BRIEF.md
# Multi-CPU Interrupt Acknowledge Controller

This block collects level-sensitive interrupt sources and presents them to up to four processors. Every ordinary source carries a route word naming the processors it may reach, a single global enable, and a mask bit per processor. Enables and masks are not written as bitmaps. Software writes a source number to a dedicated set or clear address, so one processor never has to read, modify and write state that another processor also changes.

Each processor sees one interrupt line. An acknowledge register returns the smallest source number pending for that processor, or 1023 when nothing is pending. Numbers 0 and 1 are reserved for the summary lines of an external doorbell unit (inter-processor messages and message-signalled interrupts). Number 5 is a private timer that each processor owns. These three sources take their level from per-processor inputs and depend only on that processor's mask. Reading the acknowledge register changes nothing, because the sources are level-sensitive and only drop when the device releases them.

A register bus with a window-select bit separates the shared registers from the per-processor registers. The requesting processor's number qualifies every access to the per-processor window.

Top module: `mpic_ack_ctrl`

## Requirements
- R1: After reset, every source is globally disabled, masked for every processor, and has a route word of 0. All `cpuIrq` bits are low and every acknowledge read returns 1023, whatever the input levels.
- R2: A read of shared offset 0x00 returns the number of implemented sources in bits [11:2], with all other bits 0.
- R3: A write to shared offset 0x30 enables the source whose number is in `busWdata[9:0]`, and a write to offset 0x34 disables it. A number at or above the source count is ignored and is not folded onto another source.
- R4: A per-processor write to offset 0x48 masks the numbered source (from `busWdata[9:0]`) for the processor given on `busCpu` only. A write to offset 0x4C unmasks it for that processor only.
- R5: The route word of source n is at shared offset 0x100 + 4*n. Bit k of the word, for k below the processor count, selects processor k. The word reads back with all higher bits 0.
- R6: An ordinary source (any number other than 0, 1 and 5) is pending for processor k exactly when its `srcLevel` bit is high, it is globally enabled, its route word has bit k set, and processor k has not masked it.
- R7: Source 0 is pending for processor k when `ipiSum[k]` is high and source 1 when `msiSum[k]` is high, each gated only by processor k's mask. Their `srcLevel` bits, global enables and route words have no effect.
- R8: Source 5 is pending for processor k when `timerLevel[k]` is high and processor k has not masked it. Its global enable, its route word and `srcLevel[5]` have no effect.
- R9: A per-processor read of offset 0x44 returns, in bits [9:0], the lowest source number pending for the requesting processor, or 1023 if none is pending, with bits [31:10] 0. Repeated reads return the same value and change no state.
- R10: `cpuIrq[k]` is high exactly when at least one source is pending for processor k. It follows input levels in the same cycle and register writes from the cycle after the write.
- R11: Read data appears on `busRdata` with `busRvalid` high in the cycle after `busRe` is sampled. `busRvalid` is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWe | input | 1 | Write strobe |
| busRe | input | 1 | Read strobe |
| busPerCpu | input | 1 | 1 selects the per-processor window, 0 selects the shared window |
| busCpu | input | 2 | Number of the processor making the access |
| busAddr | input | ADDR_W (12) | Byte offset within the selected window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, registered |
| busRvalid | output | 1 | Read data valid |
| srcLevel | input | NUM_SRC (32) | Level of the shared sources, one bit per number |
| ipiSum | input | NUM_CPU (4) | Per-processor message doorbell summary (source 0) |
| msiSum | input | NUM_CPU (4) | Per-processor signalled-interrupt doorbell summary (source 1) |
| timerLevel | input | NUM_CPU (4) | Per-processor private timer level (source 5) |
| cpuIrq | output | NUM_CPU (4) | Interrupt line to each processor |

## Verification
A register write takes effect at the clock edge that samples it, so `cpuIrq` and any acknowledge read started afterwards see the new state. Read data is due exactly one edge after `busRe`. The bench drives strobes on the falling edge and samples `busRdata` and `busRvalid` on the next falling edge. `cpuIrq` is combinational from the input levels, so it is checked one nanosecond after the levels change, with no clock edge in between. Every acknowledge result is compared against values the bench works out from the route, enable and mask settings it has written.

// File: rtl/mpic_pkg.sv
package mpic_pkg;
  localparam int MAX_CPU = 4;
  localparam int ID_W    = 10;
  localparam int NONE_ID = 1023;

  // strobes from bus decode to storage / selection datapath
  typedef struct packed {
    logic               setEn;
    logic               clrEn;
    logic               setMask;
    logic               clrMask;
    logic               wrRoute;
    logic               rdAny;
    logic               rdCtl;
    logic               rdAck;
    logic               rdRoute;
    logic [ID_W-1:0]    idx;
    logic [1:0]         cpu;
    logic [MAX_CPU-1:0] routeData;
  } strobe_t;
endpackage

// File: rtl/mpic_decode.sv
module mpic_decode
  import mpic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 12
) (
  input  logic              busWe,
  input  logic              busRe,
  input  logic              busPerCpu,
  input  logic [1:0]        busCpu,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output strobe_t           strobe
);
  localparam logic [ADDR_W-1:0] OFF_CTL    = ADDR_W'('h000);
  localparam logic [ADDR_W-1:0] OFF_SETEN  = ADDR_W'('h030);
  localparam logic [ADDR_W-1:0] OFF_CLREN  = ADDR_W'('h034);
  localparam logic [ADDR_W-1:0] OFF_ACK    = ADDR_W'('h044);
  localparam logic [ADDR_W-1:0] OFF_SETMSK = ADDR_W'('h048);
  localparam logic [ADDR_W-1:0] OFF_CLRMSK = ADDR_W'('h04C);
  localparam logic [ADDR_W-1:0] OFF_ROUTE  = ADDR_W'('h100);
  localparam int ROUTE_END = 'h100 + 4 * NUM_SRC;

  logic idxOk;
  logic cpuOk;
  logic routeHit;
  logic [ADDR_W-1:0] routeOff;
  logic unusedWdata;

  assign idxOk    = int'(busWdata[ID_W-1:0]) < NUM_SRC;
  assign cpuOk    = int'(busCpu) < NUM_CPU;
  assign routeOff = busAddr - OFF_ROUTE;
  assign routeHit = !busPerCpu && (busAddr >= OFF_ROUTE) &&
                    (int'(busAddr) < ROUTE_END) && (busAddr[1:0] == 2'b00);
  assign unusedWdata = ^busWdata[31:ID_W];

  always_comb begin
    strobe           = '0;
    strobe.cpu       = busCpu;
    strobe.routeData = busWdata[MAX_CPU-1:0];
    strobe.idx       = routeHit ? ID_W'(routeOff >> 2) : busWdata[ID_W-1:0];
    if (busWe) begin
      if (!busPerCpu) begin
        strobe.setEn   = (busAddr == OFF_SETEN) && idxOk;
        strobe.clrEn   = (busAddr == OFF_CLREN) && idxOk;
        strobe.wrRoute = routeHit;
      end else begin
        strobe.setMask = (busAddr == OFF_SETMSK) && idxOk && cpuOk;
        strobe.clrMask = (busAddr == OFF_CLRMSK) && idxOk && cpuOk;
      end
    end
    if (busRe) begin
      strobe.rdAny = 1'b1;
      if (!busPerCpu) begin
        strobe.rdCtl   = (busAddr == OFF_CTL);
        strobe.rdRoute = routeHit;
      end else begin
        strobe.rdAck   = (busAddr == OFF_ACK) && cpuOk;
      end
    end
  end
endmodule

// File: rtl/mpic_core.sv
module mpic_core
  import mpic_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_CPU  = 4,
  parameter int IPI_ID   = 0,
  parameter int MSI_ID   = 1,
  parameter int TIMER_ID = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobe,
  input  logic [NUM_SRC-1:0] srcLevel,
  input  logic [NUM_CPU-1:0] ipiSum,
  input  logic [NUM_CPU-1:0] msiSum,
  input  logic [NUM_CPU-1:0] timerLevel,
  output logic [NUM_CPU-1:0] cpuIrq,
  output logic [31:0]        rdData,
  output logic               rdValid
);
  logic               enableQ [NUM_SRC];
  logic [NUM_SRC-1:0] maskQ   [NUM_CPU];
  logic [NUM_CPU-1:0] routeQ  [NUM_SRC];
  logic [NUM_SRC-1:0] pend    [NUM_CPU];
  logic [ID_W-1:0]    ackId   [NUM_CPU];
  logic [31:0]        rdNext;
  logic               unusedSrc;

  assign unusedSrc = ^{srcLevel[IPI_ID], srcLevel[MSI_ID], srcLevel[TIMER_ID]};

  // global enables and route words
  genvar gi, gc;
  generate
    for (gi = 0; gi < NUM_SRC; gi++) begin : g_src
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          enableQ[gi] <= 1'b0;
          routeQ[gi]  <= '0;
        end else if (strobe.idx == ID_W'(gi)) begin
          if (strobe.setEn)   enableQ[gi] <= 1'b1;
          if (strobe.clrEn)   enableQ[gi] <= 1'b0;
          if (strobe.wrRoute) routeQ[gi]  <= strobe.routeData[NUM_CPU-1:0];
        end
      end
    end

    for (gc = 0; gc < NUM_CPU; gc++) begin : g_cpu
      // per-processor mask, one bit per source
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          maskQ[gc] <= '1;
        end else if (strobe.cpu == 2'(gc)) begin
          for (int i = 0; i < NUM_SRC; i++) begin
            if (strobe.idx == ID_W'(i)) begin
              if (strobe.setMask) maskQ[gc][i] <= 1'b1;
              if (strobe.clrMask) maskQ[gc][i] <= 1'b0;
            end
          end
        end
      end

      for (gi = 0; gi < NUM_SRC; gi++) begin : g_pend
        if (gi == IPI_ID) begin : g_ipi
          assign pend[gc][gi] = ipiSum[gc] & ~maskQ[gc][gi];
        end else if (gi == MSI_ID) begin : g_msi
          assign pend[gc][gi] = msiSum[gc] & ~maskQ[gc][gi];
        end else if (gi == TIMER_ID) begin : g_tmr
          assign pend[gc][gi] = timerLevel[gc] & ~maskQ[gc][gi];
        end else begin : g_ord
          assign pend[gc][gi] = srcLevel[gi] & enableQ[gi] &
                                routeQ[gi][gc] & ~maskQ[gc][gi];
        end
      end

      // lowest pending number wins
      always_comb begin
        ackId[gc] = ID_W'(NONE_ID);
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
          if (pend[gc][i]) ackId[gc] = ID_W'(i);
        end
      end

      assign cpuIrq[gc] = |pend[gc];
    end
  endgenerate

  always_comb begin
    rdNext = '0;
    if (strobe.rdCtl) rdNext[ID_W+1:2] = ID_W'(NUM_SRC);
    if (strobe.rdRoute) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (strobe.idx == ID_W'(i)) rdNext[NUM_CPU-1:0] = routeQ[i];
      end
    end
    if (strobe.rdAck) begin
      for (int c = 0; c < NUM_CPU; c++) begin
        if (strobe.cpu == 2'(c)) rdNext[ID_W-1:0] = ackId[c];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strobe.rdAny;
      if (strobe.rdAny) rdData <= rdNext;
    end
  end
endmodule

// File: rtl/mpic_ack_ctrl.sv
module mpic_ack_ctrl
  import mpic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWe,
  input  logic               busRe,
  input  logic               busPerCpu,
  input  logic [1:0]         busCpu,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [31:0]        busWdata,
  output logic [31:0]        busRdata,
  output logic               busRvalid,
  input  logic [NUM_SRC-1:0] srcLevel,
  input  logic [NUM_CPU-1:0] ipiSum,
  input  logic [NUM_CPU-1:0] msiSum,
  input  logic [NUM_CPU-1:0] timerLevel,
  output logic [NUM_CPU-1:0] cpuIrq
);
  strobe_t strobe;

  mpic_decode #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) u_decode (
    .busWe(busWe), .busRe(busRe), .busPerCpu(busPerCpu), .busCpu(busCpu),
    .busAddr(busAddr), .busWdata(busWdata), .strobe(strobe)
  );

  mpic_core #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_core (
    .clk(clk), .rstN(rstN), .strobe(strobe), .srcLevel(srcLevel),
    .ipiSum(ipiSum), .msiSum(msiSum), .timerLevel(timerLevel),
    .cpuIrq(cpuIrq), .rdData(busRdata), .rdValid(busRvalid)
  );
endmodule

// File: rtl/mpic_ack_ctrl_chk.sv
module mpic_ack_ctrl_chk #(
  parameter int NUM_SRC = 32,
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 12
) (
  input logic               clk,
  input logic               rstN,
  input logic               busRe,
  input logic               busPerCpu,
  input logic [1:0]         busCpu,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [31:0]        busRdata,
  input logic               busRvalid,
  input logic [NUM_SRC-1:0] srcLevel,
  input logic [NUM_CPU-1:0] ipiSum,
  input logic [NUM_CPU-1:0] msiSum,
  input logic [NUM_CPU-1:0] timerLevel,
  input logic [NUM_CPU-1:0] cpuIrq
);
  logic ackPend, ctlPend, irqSnap, irqNow;

  always_comb begin
    irqNow = 1'b0;
    for (int c = 0; c < NUM_CPU; c++) if (busCpu == 2'(c)) irqNow = cpuIrq[c];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackPend <= 1'b0;
      ctlPend <= 1'b0;
      irqSnap <= 1'b0;
    end else begin
      ackPend <= busRe && busPerCpu && (busAddr == ADDR_W'('h44)) && (int'(busCpu) < NUM_CPU);
      ctlPend <= busRe && !busPerCpu && (busAddr == ADDR_W'('h00));
      irqSnap <= irqNow;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> cpuIrq == '0);
  assert_ctl_count_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctlPend |-> busRdata == 32'(NUM_SRC << 2));
  assert_idle_inputs_R6: assert property (@(posedge clk) disable iff (!rstN)
    (srcLevel == '0 && ipiSum == '0 && msiSum == '0 && timerLevel == '0) |-> cpuIrq == '0);
  assert_ack_range_R9: assert property (@(posedge clk) disable iff (!rstN)
    ackPend |-> (busRdata[31:10] == '0 &&
                 (busRdata[9:0] == 10'd1023 || int'(busRdata[9:0]) < NUM_SRC)));
  assert_ack_vs_line_R10: assert property (@(posedge clk) disable iff (!rstN)
    ackPend |-> ((busRdata[9:0] == 10'd1023) == !irqSnap));
  assert_rvalid_due_R11: assert property (@(posedge clk) disable iff (!rstN)
    busRe |=> busRvalid);
  assert_rvalid_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !busRe |=> !busRvalid);
endmodule

bind mpic_ack_ctrl mpic_ack_ctrl_chk #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busRe(busRe), .busPerCpu(busPerCpu), .busCpu(busCpu),
  .busAddr(busAddr), .busRdata(busRdata), .busRvalid(busRvalid), .srcLevel(srcLevel),
  .ipiSum(ipiSum), .msiSum(msiSum), .timerLevel(timerLevel), .cpuIrq(cpuIrq)
);

// File: tb/mpic_ack_ctrl_tb.sv
`timescale 1ns/1ps
module mpic_ack_ctrl_tb;
  localparam int NS = 32;
  localparam int NC = 4;
  localparam logic [9:0] N = 10'd1023;

  typedef struct packed {
    logic [31:0] src;
    logic [3:0]  ipi, msi, tmr;
    logic [9:0]  a0, a1, a2, a3;
  } vec_t;

  // setup: route n -> cpu (n%4), route 9 -> cpus 0,1; source 7 disabled; cpu2 masks 6
  localparam vec_t VECS [0:10] = '{
    '{32'h0000_0000, 4'h0, 4'h0, 4'h0, N,     N,     N,      N},
    '{32'h0000_0010, 4'h0, 4'h0, 4'h0, 10'd4, N,     N,      N},
    '{32'h0000_0200, 4'h0, 4'h0, 4'h0, 10'd9, 10'd9, N,      N},
    '{32'h0000_0440, 4'h0, 4'h0, 4'h0, N,     N,     10'd10, N},
    '{32'h0000_0080, 4'h0, 4'h0, 4'h0, N,     N,     N,      N},
    '{32'h8000_0008, 4'h0, 4'h0, 4'h0, N,     N,     N,      10'd3},
    '{32'h0000_0010, 4'h0, 4'h0, 4'h5, 10'd4, N,     10'd5,  N},
    '{32'h0000_0004, 4'h2, 4'h3, 4'h0, 10'd1, 10'd0, 10'd2,  N},
    '{32'h0000_0020, 4'h0, 4'h0, 4'h0, N,     N,     N,      N},
    '{32'hFFFF_FFFF, 4'h0, 4'h0, 4'h0, 10'd4, 10'd9, 10'd2,  10'd3},
    '{32'hFFFF_FFE0, 4'h0, 4'h0, 4'h0, 10'd8, 10'd9, 10'd10, 10'd11}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWe = 1'b0, busRe = 1'b0, busPerCpu = 1'b0;
  logic [1:0]  busCpu = '0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busRvalid;
  logic [NS-1:0] srcLevel = '0;
  logic [NC-1:0] ipiSum = '0, msiSum = '0, timerLevel = '0;
  logic [NC-1:0] cpuIrq;
  int nChk = 0, nFail = 0;

  always #4 clk = ~clk;

  mpic_ack_ctrl u_dut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busRe(busRe), .busPerCpu(busPerCpu),
    .busCpu(busCpu), .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .busRvalid(busRvalid), .srcLevel(srcLevel), .ipiSum(ipiSum), .msiSum(msiSum),
    .timerLevel(timerLevel), .cpuIrq(cpuIrq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic pc, input int cpu, input int addr, input logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busPerCpu = pc; busCpu = 2'(cpu); busAddr = 12'(addr); busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic pc, input int cpu, input int addr, output logic [31:0] d);
    @(negedge clk);
    busRe = 1'b1; busPerCpu = pc; busCpu = 2'(cpu); busAddr = 12'(addr);
    @(negedge clk);
    busRe = 1'b0;
    d = busRdata;
  endtask

  task automatic ack(input int cpu, input logic [9:0] exp, input string req);
    logic [31:0] d;
    rd(1'b1, cpu, 'h44, d);
    chk(req, d, {22'b0, exp});
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] d;
    // R1: reset state with every input high
    srcLevel = '1; ipiSum = '1; msiSum = '1; timerLevel = '1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1 chk("R1 cpuIrq after reset", 32'(cpuIrq), 0);
    for (int c = 0; c < NC; c++) ack(c, N, "R1 ack after reset");
    rd(1'b0, 0, 'h100 + 4*4, d);
    chk("R1 route word reset", d, 0);
    chk("R11 rvalid with read data", 32'(busRvalid), 1);
    // R6: enabled and routed but still masked
    wr(1'b0, 0, 'h30, 4);
    wr(1'b0, 0, 'h100 + 4*4, 1);
    ack(0, N, "R6 masked source not pending");
    srcLevel = '0; ipiSum = '0; msiSum = '0; timerLevel = '0;

    // configuration for the table
    for (int r = 2; r < NS; r++) wr(1'b0, 0, 'h100 + 4*r, (r == 9) ? 32'h3 : 32'(1 << (r % 4)));
    for (int r = 2; r < NS; r++) if (r != 7) wr(1'b0, 0, 'h30, r);
    for (int c = 0; c < NC; c++)
      for (int r = 0; r < NS; r++) wr(1'b1, c, 'h4C, r);
    wr(1'b1, 2, 'h48, 6);

    // table walk: R6 R7 R8 R9 R10
    for (int v = 0; v < 11; v++) begin
      @(negedge clk);
      srcLevel = VECS[v].src; ipiSum = VECS[v].ipi; msiSum = VECS[v].msi; timerLevel = VECS[v].tmr;
      #1;
      chk("R10 cpuIrq pattern", 32'(cpuIrq),
          {28'b0, VECS[v].a3 != N, VECS[v].a2 != N, VECS[v].a1 != N, VECS[v].a0 != N});
      ack(0, VECS[v].a0, "R6/R7/R8/R9 table cpu0");
      ack(1, VECS[v].a1, "R6/R7/R8/R9 table cpu1");
      ack(2, VECS[v].a2, "R6/R7/R8/R9 table cpu2");
      ack(3, VECS[v].a3, "R6/R7/R8/R9 table cpu3");
    end
    srcLevel = '0; ipiSum = '0; msiSum = '0; timerLevel = '0;

    // R2: source count
    rd(1'b0, 0, 'h00, d);
    chk("R2 control count", d, 32'(NS << 2));
    // R5: route readback keeps only processor bits
    wr(1'b0, 0, 'h100 + 4*12, 32'hFFFF_FFFF);
    rd(1'b0, 0, 'h100 + 4*12, d);
    chk("R5 route readback", d, 32'hF);
    wr(1'b0, 0, 'h100 + 4*12, 32'h1);
    // R3: out-of-range number ignored, then real disable
    srcLevel = 32'h10;
    wr(1'b0, 0, 'h34, 36);
    ack(0, 10'd4, "R3 out-of-range clear ignored");
    wr(1'b0, 0, 'h34, 4);
    ack(0, N, "R3 cleared enable");
    #1 chk("R10 line low after disable", 32'(cpuIrq[0]), 0);
    wr(1'b0, 0, 'h30, 4);
    ack(0, 10'd4, "R3 re-enabled");
    // R4: mask affects only the calling processor
    srcLevel = 32'h200;
    wr(1'b1, 1, 'h48, 9);
    ack(1, N, "R4 cpu1 masked");
    ack(0, 10'd9, "R4 cpu0 unaffected");
    ack(0, 10'd9, "R9 repeated read same");
    // R8: timer ignores enable and route
    srcLevel = '0;
    wr(1'b0, 0, 'h34, 5);
    wr(1'b0, 0, 'h100 + 4*5, 0);
    timerLevel = 4'b1000;
    ack(3, 10'd5, "R8 timer without enable");
    wr(1'b1, 3, 'h48, 5);
    ack(3, N, "R8 timer masked");
    timerLevel = '0;
    // R7: doorbell summary ignores enable
    ipiSum = 4'b0001;
    wr(1'b0, 0, 'h34, 0);
    ack(0, 10'd0, "R7 doorbell without enable");
    wr(1'b1, 0, 'h48, 0);
    ack(0, N, "R7 doorbell masked");
    ipiSum = '0;
    @(negedge clk);
    summary();
  end
endmodule